// File: doc/BRIEF.md
# Subcode Frame Capture and Qualification Filter

This block listens to a two-wire synchronous serial link (clock and data, both driven by an external disc controller) and assembles each 12-byte subcode frame, bits arriving least significant first. Both wires are brought into the system clock domain through a short synchronizer chain. The serial clock's rising edges are found there and used to sample data. Before each frame the block waits a fixed number of system clocks, and any serial activity in that window is discarded. This skips the tail of the previous transfer and keeps byte alignment. Each finished frame appears on a wide output together with a one-cycle valid strobe.

Every completed frame is classified. A hit is either a lead-in table-of-contents point on a data sector, or a frame that keeps up tracking once the counter is already running. A small leaky counter rises by one on each hit and falls by one, down to zero, on each miss. When it reaches the trigger level, an inject request is raised and held. While the request is up, frames do not move the counter. When the request is acknowledged, the counter drops to the trigger level minus a gap. That gap sets a cool-off of several qualifying frames before the next request.

Top module: `subcode_hit_filter`

## Requirements
- R1: A frame is 8*FRAME_BYTES serial bits, sampled on rising edges of the serial clock, least significant bit of each byte first. Byte k appears at frame_bytes_o[8k+7:8k]. frame_valid_o pulses for one cycle as the buffer updates, and the buffer holds its value otherwise.
- R2: After reset and after each frame, serial clock edges during the following IDLE_CYCLES system clocks are ignored and do not shift into the next frame.
- R3: A frame can only be a hit when byte 1 and byte 6 are both 0x00.
- R4: Byte 0 marks a data sector when (byte0 & 0xD0) == 0x40, that is bit 6 set and bits 7 and 4 clear.
- R5: A synced data-sector frame is a hit if byte 2 >= 0xA0, or if byte 2 == 0x01 and (byte3 - 0x03) mod 256 >= 0xF5.
- R6: A synced frame is also a hit when the counter is nonzero and either byte 0 == 0x01 or the frame is a data sector.
- R7: The counter changes only in the cycle after frame_valid_o or after an accepted acknowledge. A hit adds one; a miss subtracts one, saturating at zero.
- R8: inj_req_o is high exactly while the counter is at or above TRIGGER (default 10). While it is high, frames leave the counter unchanged.
- R9: inj_ack_i while inj_req_o is high reloads the counter to TRIGGER-GAP (default 5) in the next cycle. inj_ack_i while inj_req_o is low has no effect.
- R10: Reset clears the counter, the request, the strobe and the frame buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sq_clk_i | input | 1 | Serial subcode clock from the controller, idles high |
| sq_dat_i | input | 1 | Serial subcode data |
| inj_ack_i | input | 1 | Acknowledge of a pending inject request |
| frame_valid_o | output | 1 | One-cycle strobe when a frame completes |
| frame_bytes_o | output | 8*FRAME_BYTES (96) | Last completed frame, byte k at bits 8k+7:8k |
| hit_count_o | output | $clog2(TRIGGER+1) (4) | Current hit counter |
| inj_req_o | output | 1 | Inject request, high while the counter is at or above TRIGGER |

## Verification
Byte-distinct frames show whether bit order and byte placement are right. A burst of serial edges right after a frame, followed by a clean frame, shows whether the idle window really discards the burst or lets it shift into the next frame. For the lead-in rule, single frames from a cleared counter are used, with byte 3 placed on each side of the wrap boundary and byte 0 placed on each side of the control mask. These cases separate the lead-in rule from the tracking rule, which only applies once the counter is nonzero. Runs of hits, then misses, out-of-sync frames and acknowledges walk the counter through the trigger, the freeze, the reload and the floor at zero.

// File: rtl/subcode_pkg.sv
package subcode_pkg;

    typedef logic [7:0] byte_t;

    // Control byte qualification for a data sector
    localparam byte_t CTRL_MASK   = 8'hD0;
    localparam byte_t CTRL_MATCH  = 8'h40;
    // Point field thresholds
    localparam byte_t POINT_TOC   = 8'hA0;
    localparam byte_t POINT_TRK1  = 8'h01;
    localparam byte_t WRAP_BIAS   = 8'h03;
    localparam byte_t WRAP_FLOOR  = 8'hF5;
    localparam byte_t TRACK_MODE  = 8'h01;

    typedef enum logic {
        ASM_IDLE  = 1'b0,
        ASM_SHIFT = 1'b1
    } asm_state_t;

    // The subset of frame bytes that the qualification rules look at
    typedef struct packed {
        byte_t ctrl;   // byte 0
        byte_t sync_a; // byte 1
        byte_t point;  // byte 2
        byte_t minute; // byte 3
        byte_t sync_b; // byte 6
    } key_bytes_t;

    typedef struct packed {
        logic synced;
        logic data_sector;
        logic lead_in;
        logic tracking;
    } frame_class_t;

    function automatic logic is_data_sector(byte_t ctrl);
        return (ctrl & CTRL_MASK) == CTRL_MATCH;
    endfunction

    function automatic logic is_lead_in_point(byte_t point, byte_t minute);
        byte_t shifted;
        shifted = minute - WRAP_BIAS;
        return (point >= POINT_TOC) ||
               ((point == POINT_TRK1) && (shifted >= WRAP_FLOOR));
    endfunction

endpackage

// File: rtl/sc_edge_sync.sv
module sc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic bit_rise,
    output logic bit_val
);

    // One extra stage on the clock path keeps the previous level for edge detect
    logic [STAGES:0]   clk_pipe;
    logic [STAGES-1:0] dat_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_pipe <= '1;
            dat_pipe <= '0;
        end else begin
            clk_pipe <= {clk_pipe[STAGES-1:0], ser_clk};
            dat_pipe <= {dat_pipe[STAGES-2:0], ser_dat};
        end
    end

    assign bit_rise = clk_pipe[STAGES-1] & ~clk_pipe[STAGES];
    assign bit_val  = dat_pipe[STAGES-1];

endmodule

// File: rtl/sc_frame_assembler.sv
module sc_frame_assembler
    import subcode_pkg::*;
#(
    parameter int FRAME_BYTES = 12,
    parameter int IDLE_CYCLES = 250000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bit_rise,
    input  logic                     bit_val,
    output logic                     frame_valid,
    output logic [8*FRAME_BYTES-1:0] frame_bytes
);

    localparam int FRAME_BITS = 8 * FRAME_BYTES;
    localparam int SH_W       = FRAME_BITS - 1;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int IDLE_W     = $clog2(IDLE_CYCLES + 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_BITS - 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYCLES - 1);

    asm_state_t        state;
    logic [IDLE_W-1:0] idle_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [SH_W-1:0]   shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ASM_IDLE;
            idle_cnt    <= '0;
            bit_cnt     <= '0;
            shreg       <= '0;
            frame_valid <= 1'b0;
            frame_bytes <= '0;
        end else begin
            frame_valid <= 1'b0;
            case (state)
                ASM_IDLE: begin
                    // Serial edges are dropped here: skips the previous tail
                    if (idle_cnt == IDLE_LAST) begin
                        idle_cnt <= '0;
                        bit_cnt  <= '0;
                        state    <= ASM_SHIFT;
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                ASM_SHIFT: begin
                    if (bit_rise) begin
                        shreg <= {bit_val, shreg[SH_W-1:1]};
                        if (bit_cnt == BIT_LAST) begin
                            frame_bytes <= {bit_val, shreg};
                            frame_valid <= 1'b1;
                            bit_cnt     <= '0;
                            state       <= ASM_IDLE;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ASM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sc_frame_classifier.sv
module sc_frame_classifier
    import subcode_pkg::*;
(
    input  key_bytes_t   keys,
    input  logic         count_nonzero,
    output frame_class_t cls,
    output logic         hit
);

    always_comb begin
        cls.synced      = (keys.sync_a == 8'h00) && (keys.sync_b == 8'h00);
        cls.data_sector = is_data_sector(keys.ctrl);
        cls.lead_in     = cls.data_sector &&
                          is_lead_in_point(keys.point, keys.minute);
        cls.tracking    = count_nonzero &&
                          ((keys.ctrl == TRACK_MODE) || cls.data_sector);
        hit             = cls.synced && (cls.lead_in || cls.tracking);
    end

endmodule

// File: rtl/sc_hit_counter.sv
module sc_hit_counter #(
    parameter int TRIGGER = 10,
    parameter int GAP     = 5,
    parameter int CNT_W   = $clog2(TRIGGER + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_valid,
    input  logic             hit,
    input  logic             inj_ack,
    output logic [CNT_W-1:0] count,
    output logic             inj_req
);

    localparam logic [CNT_W-1:0] TRIG_LVL = CNT_W'(TRIGGER);
    localparam logic [CNT_W-1:0] RELOAD   = CNT_W'(TRIGGER - GAP);

    assign inj_req = (count >= TRIG_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inj_ack && inj_req) begin
            count <= RELOAD;
        end else if (frame_valid && !inj_req) begin
            if (hit) begin
                count <= count + 1'b1;
            end else if (count != '0) begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/subcode_hit_filter.sv
module subcode_hit_filter
    import subcode_pkg::*;
#(
    parameter int FRAME_BYTES = 12,
    parameter int IDLE_CYCLES = 250000,
    parameter int SYNC_STAGES = 2,
    parameter int TRIGGER     = 10,
    parameter int GAP         = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              sq_clk_i,
    input  logic                              sq_dat_i,
    input  logic                              inj_ack_i,
    output logic                              frame_valid_o,
    output logic [8*FRAME_BYTES-1:0]          frame_bytes_o,
    output logic [$clog2(TRIGGER+1)-1:0]      hit_count_o,
    output logic                              inj_req_o
);

    localparam int CNT_W = $clog2(TRIGGER + 1);

    logic         bit_rise;
    logic         bit_val;
    key_bytes_t   keys;
    frame_class_t cls;
    logic         hit;

    sc_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (sq_clk_i),
        .ser_dat  (sq_dat_i),
        .bit_rise (bit_rise),
        .bit_val  (bit_val)
    );

    sc_frame_assembler #(
        .FRAME_BYTES (FRAME_BYTES),
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_asm (
        .clk         (clk),
        .rst         (rst),
        .bit_rise    (bit_rise),
        .bit_val     (bit_val),
        .frame_valid (frame_valid_o),
        .frame_bytes (frame_bytes_o)
    );

    assign keys.ctrl   = frame_bytes_o[7:0];
    assign keys.sync_a = frame_bytes_o[15:8];
    assign keys.point  = frame_bytes_o[23:16];
    assign keys.minute = frame_bytes_o[31:24];
    assign keys.sync_b = frame_bytes_o[55:48];

    sc_frame_classifier u_cls (
        .keys          (keys),
        .count_nonzero (|hit_count_o),
        .cls           (cls),
        .hit           (hit)
    );

    sc_hit_counter #(
        .TRIGGER (TRIGGER),
        .GAP     (GAP),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid_o),
        .hit         (hit),
        .inj_ack     (inj_ack_i),
        .count       (hit_count_o),
        .inj_req     (inj_req_o)
    );

endmodule

// File: rtl/sc_filter_checker.sv
module sc_filter_checker #(
    parameter int FRAME_BYTES = 12,
    parameter int TRIGGER     = 10,
    parameter int GAP         = 5
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          inj_ack_i,
    input logic                          frame_valid_o,
    input logic [8*FRAME_BYTES-1:0]      frame_bytes_o,
    input logic [$clog2(TRIGGER+1)-1:0]  hit_count_o,
    input logic                          inj_req_o
);

    localparam int RELOAD = TRIGGER - GAP;

    // R1: the strobe lasts a single cycle
    assert_valid_single_R1: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |=> !frame_valid_o);

    // R1: buffer only changes together with the strobe
    assert_bytes_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !frame_valid_o |-> $stable(frame_bytes_o));

    // R7: no frame and no accepted ack means no counter movement
    assert_count_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(frame_valid_o) && !$past(inj_ack_i && inj_req_o))
        |-> $stable(hit_count_o));

    // R7: a frame moves the counter by one step or holds it at the floor
    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_valid_o) && !$past(inj_req_o))
        |-> ((int'(hit_count_o) == int'($past(hit_count_o)) + 1) ||
             (int'(hit_count_o) == int'($past(hit_count_o)) - 1) ||
             (hit_count_o == '0 && $past(hit_count_o) == '0)));

    // R8: frames while the request is up leave the counter alone
    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_valid_o) && $past(inj_req_o) && !$past(inj_ack_i))
        |-> $stable(hit_count_o));

    // R9: an accepted acknowledge reloads below the trigger
    assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
        $past(inj_ack_i && inj_req_o) |-> (int'(hit_count_o) == RELOAD));

    // R9: an acknowledge without a request changes nothing
    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(inj_ack_i) && !$past(inj_req_o) && !$past(frame_valid_o))
        |-> $stable(hit_count_o));

endmodule

bind subcode_hit_filter sc_filter_checker #(
    .FRAME_BYTES (FRAME_BYTES),
    .TRIGGER     (TRIGGER),
    .GAP         (GAP)
) u_checker (
    .clk           (clk),
    .rst           (rst),
    .inj_ack_i     (inj_ack_i),
    .frame_valid_o (frame_valid_o),
    .frame_bytes_o (frame_bytes_o),
    .hit_count_o   (hit_count_o),
    .inj_req_o     (inj_req_o)
);

// File: tb/subcode_hit_filter_test.sv
`timescale 1ns/1ps
module subcode_hit_filter_test;

    localparam int IDLE = 40;
    localparam int NB   = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sq_clk = 1'b1;
    logic        sq_dat = 1'b0;
    logic        ack = 1'b0;
    logic        fvalid;
    logic [95:0] fbytes;
    logic [3:0]  cnt;
    logic        req;

    int checks = 0;
    int errors = 0;
    int vcount = 0;

    always #2 clk = ~clk; // 250 MHz

    subcode_hit_filter #(
        .FRAME_BYTES (NB),
        .IDLE_CYCLES (IDLE),
        .SYNC_STAGES (2),
        .TRIGGER     (10),
        .GAP         (5)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .sq_clk_i      (sq_clk),
        .sq_dat_i      (sq_dat),
        .inj_ack_i     (ack),
        .frame_valid_o (fvalid),
        .frame_bytes_o (fbytes),
        .hit_count_o   (cnt),
        .inj_req_o     (req)
    );

    always @(posedge clk) begin
        if (rst) vcount <= 0;
        else if (fvalid) vcount <= vcount + 1;
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sq_clk = 1'b1;
        ack = 1'b0;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(1);
    endtask

    function automatic logic [95:0] mk(input logic [7:0] b0, input logic [7:0] b1,
                                       input logic [7:0] b2, input logic [7:0] b3,
                                       input logic [7:0] b6);
        logic [95:0] f;
        for (int k = 0; k < NB; k++) f[8*k +: 8] = 8'(8'h10 + k);
        f[7:0]   = b0;
        f[15:8]  = b1;
        f[23:16] = b2;
        f[31:24] = b3;
        f[55:48] = b6;
        return f;
    endfunction

    task automatic send_frame(input logic [95:0] f);
        wait_clks(IDLE + 10);
        for (int i = 0; i < 96; i++) begin
            sq_dat = f[i];
            sq_clk = 1'b0;
            wait_clks(4);
            sq_clk = 1'b1;
            wait_clks(4);
        end
        wait_clks(6);
    endtask

    task automatic send_check(input logic [95:0] f, input int exp_cnt, input string tag);
        send_frame(f);
        check_eq(tag, "hit count", int'(cnt), exp_cnt);
    endtask

    task automatic test_reset();
        do_reset();
        check_eq("R10", "count after reset", int'(cnt), 0);
        check_eq("R10", "request after reset", int'(req), 0);
        check_eq("R10", "strobe after reset", int'(fvalid), 0);
        check_eq("R10", "buffer after reset nonzero", int'(fbytes != '0), 0);
    endtask

    task automatic test_capture();
        logic [95:0] f;
        int v0;
        do_reset();
        for (int k = 0; k < NB; k++) f[8*k +: 8] = 8'(k * 37 + 11);
        v0 = vcount;
        send_frame(f);
        for (int k = 0; k < NB; k++)
            check_eq("R1", $sformatf("byte %0d", k), int'(fbytes[8*k +: 8]), int'(f[8*k +: 8]));
        check_eq("R1", "strobes per frame", vcount - v0, 1);
    endtask

    task automatic test_idle_skip();
        logic [95:0] fa;
        logic [95:0] fb;
        int v0;
        do_reset();
        fa = mk(8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
        fb = mk(8'h9C, 8'h01, 8'h7E, 8'hE1, 8'h0F);
        v0 = vcount;
        send_frame(fa);
        // burst of edges inside the idle window
        for (int i = 0; i < 3; i++) begin
            sq_dat = 1'b1;
            sq_clk = 1'b0;
            wait_clks(3);
            sq_clk = 1'b1;
            wait_clks(3);
        end
        send_frame(fb);
        check_eq("R2", "strobes for two frames", vcount - v0, 2);
        for (int k = 0; k < NB; k++)
            check_eq("R2", $sformatf("byte %0d after burst", k), int'(fbytes[8*k +: 8]), int'(fb[8*k +: 8]));
    endtask

    task automatic one_leadin(input logic [7:0] b0, input logic [7:0] b2,
                              input logic [7:0] b3, input int exp, input string tag);
        do_reset();
        send_check(mk(b0, 8'h00, b2, b3, 8'h00), exp, tag);
    endtask

    task automatic test_leadin();
        one_leadin(8'h41, 8'hA0, 8'h00, 1, "R5");
        one_leadin(8'h41, 8'hFF, 8'h00, 1, "R5");
        one_leadin(8'h41, 8'h9F, 8'h00, 0, "R5");
        one_leadin(8'h41, 8'h01, 8'h02, 1, "R5");
        one_leadin(8'h41, 8'h01, 8'h03, 0, "R5");
        one_leadin(8'h41, 8'h01, 8'hF8, 1, "R5");
        one_leadin(8'h41, 8'h01, 8'hF7, 0, "R5");
        one_leadin(8'h61, 8'hA1, 8'h00, 1, "R4");
        one_leadin(8'h51, 8'hA0, 8'h00, 0, "R4");
        one_leadin(8'hC1, 8'hA0, 8'h00, 0, "R4");
        one_leadin(8'h01, 8'hA0, 8'h00, 0, "R4");
    endtask

    task automatic test_sync();
        do_reset();
        send_check(mk(8'h41, 8'h00, 8'hA0, 8'h00, 8'h80), 0, "R3");
        send_check(mk(8'h41, 8'h01, 8'hA0, 8'h00, 8'h00), 0, "R3");
        send_check(mk(8'h41, 8'h00, 8'hA0, 8'h00, 8'h00), 1, "R3");
        send_check(mk(8'h01, 8'h00, 8'h00, 8'h00, 8'h10), 0, "R3");
    endtask

    task automatic test_track();
        do_reset();
        send_check(mk(8'h01, 8'h00, 8'h00, 8'h00, 8'h00), 0, "R6");
        send_check(mk(8'h41, 8'h00, 8'hA0, 8'h00, 8'h00), 1, "R6");
        send_check(mk(8'h01, 8'h00, 8'h00, 8'h00, 8'h00), 2, "R6");
        send_check(mk(8'h41, 8'h00, 8'h05, 8'h00, 8'h00), 3, "R6");
        send_check(mk(8'h50, 8'h00, 8'h00, 8'h00, 8'h00), 2, "R7");
        send_check(mk(8'hC0, 8'h00, 8'h00, 8'h00, 8'h00), 1, "R7");
        send_check(mk(8'h02, 8'h00, 8'h00, 8'h00, 8'h00), 0, "R7");
        send_check(mk(8'h02, 8'h00, 8'h00, 8'h00, 8'h00), 0, "R7");
    endtask

    task automatic test_trigger();
        logic [95:0] hitf;
        hitf = mk(8'h41, 8'h00, 8'hA0, 8'h00, 8'h00);
        do_reset();
        for (int i = 1; i <= 9; i++) send_frame(hitf);
        check_eq("R8", "count below trigger", int'(cnt), 9);
        check_eq("R8", "request below trigger", int'(req), 0);
        send_frame(hitf);
        check_eq("R8", "count at trigger", int'(cnt), 10);
        check_eq("R8", "request at trigger", int'(req), 1);
        send_frame(mk(8'h02, 8'h33, 8'h00, 8'h00, 8'h00));
        check_eq("R8", "count frozen during request", int'(cnt), 10);
        check_eq("R8", "request held", int'(req), 1);
        ack = 1'b1;
        wait_clks(1);
        ack = 1'b0;
        wait_clks(1);
        check_eq("R9", "count after ack", int'(cnt), 5);
        check_eq("R9", "request after ack", int'(req), 0);
        ack = 1'b1;
        wait_clks(1);
        ack = 1'b0;
        wait_clks(1);
        check_eq("R9", "count after stray ack", int'(cnt), 5);
        send_check(mk(8'h02, 8'h33, 8'h00, 8'h00, 8'h00), 4, "R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_capture();
        test_idle_skip();
        test_leadin();
        test_sync();
        test_track();
        test_trigger();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule